// File: doc/BRIEF.md
# Auto-Increment Packet Buffer Access Port

This block lets a host reach a 16 KB packet buffer through a few strobes instead of a wide address bus. The buffer is split in two regions: the low 3 KB (0x0000 to 0x0BFF) holds frames waiting to be sent, and the rest (0x0C00 to 0x3FFF) is a ring of received frames. The host loads a start address once. It then streams bytes or 16-bit halfwords in and out, and the block moves the address forward after each transfer.

Reads go through a prefetch latch. A priming command (a dummy read, or a dummy write) fetches the word at the current address into the latch. Each later read command returns the latch contents, steps the address and fetches the next location. For this reason the value returned by the dummy read belongs to whatever was fetched before, and the host must throw it away.

A wrap-enable input confines bursts to their region. With wrap enabled, a write stream that runs off the end of the transmit area returns to 0x0000. A read stream that runs off the top of the buffer returns to 0x0C00, the start of the receive ring. The buffer is a synchronous single-port SRAM, 16 bits wide, with a byte enable for each lane and one cycle of read latency.

Top module: `autoinc_mem_port`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, curAddr and rdData are 0 and memEn is 0.
- R2: A pulse on addrLoad puts loadValue into curAddr one cycle later. addrLoad wins over every other command in the same cycle.
- R3: A dummy read places the current latch contents on rdData one cycle later and leaves curAddr unchanged. The latch contents are stale data from the previous fetch, or 0 after reset. The dummy read then refills the latch from the current (aligned) address.
- R4: A read command places the latch contents on rdData one cycle later, advances curAddr and refills the latch from the new address. Read commands may come on back-to-back cycles.
- R5: In 8-bit mode (wideMode=0) the step is 1 and rdData[15:8] is 0. In 16-bit mode the address is forced even for the access and the step is 2. The data is little-endian: bits 7:0 hold the even byte and bits 15:8 hold the odd byte.
- R6: A write command stores wrData at the current address and advances curAddr. In 8-bit mode it stores wrData[7:0] into one byte. In 16-bit mode it stores both bytes. A write does not change rdData.
- R7: With wrapEn=1, a write advance from below 0x0C00 that would reach 0x0C00 or beyond sets curAddr to 0x0000.
- R8: With wrapEn=1, a read advance that would reach 0x4000 sets curAddr to 0x0C00.
- R9: With wrapEn=0, every advance is taken modulo 0x4000.
- R10: A dummy write writes no memory, leaves curAddr and rdData unchanged, and refills the latch from the current address.
- R11: When several commands are asserted in the same cycle, only one takes effect. The order is: address load first, then read, then write, then dummy read, then dummy write.
- R12: curAddr always shows the address register, one cycle after each command that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | 1 = 16-bit transfers, 0 = 8-bit |
| wrapEn | input | 1 | Enables region wrap for write and read bursts |
| addrLoad | input | 1 | Load the start address |
| loadValue | input | 14 | Start address to load |
| dummyRd | input | 1 | Dummy read: priming fetch, returns stale data |
| dummyWr | input | 1 | Dummy write: priming fetch, no memory write |
| rdCmd | input | 1 | Read command |
| wrCmd | input | 1 | Write command |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid the cycle after a read or dummy read |
| curAddr | output | 14 | Current byte address |
| memEn | output | 1 | SRAM enable |
| memWe | output | 1 | SRAM write enable |
| memBe | output | 2 | SRAM byte-lane enables |
| memAddr | output | 13 | SRAM word address |
| memWdata | output | 16 | SRAM write data |
| memRdata | input | 16 | SRAM read data, one cycle after the enable |

## Verification
The assertions check these rules on every cycle:
- an address load lands as commanded;
- curAddr holds when no read, write or load is issued;
- wrapped write streams stay inside the transmit area, and wrapped read streams stay inside the receive area;
- a dummy command never drives the SRAM write enable;
- 16-bit writes enable both lanes.

Other behaviour can only be shown by the bench's scenarios, because it depends on memory contents across many commands:
- the stale value returned by a dummy read;
- the prefetch pipeline when read commands come back to back;
- byte order in 16-bit mode;
- that a write losing a collision leaves memory untouched.

// File: rtl/autoinc_port_pkg.sv
package autoinc_port_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_READ,
    OP_WRITE,
    OP_DUMMY_RD,
    OP_DUMMY_WR
  } hostOp_e;

  typedef struct packed {
    logic loadAddr;    // take loadValue into the address register
    logic advance;     // step the address register
    logic dirWrite;    // advance belongs to a write (selects wrap region)
    logic memRead;     // issue a prefetch read this cycle
    logic readAtNext;  // prefetch the next address instead of the current one
    logic memWrite;    // write host data this cycle
    logic outUpdate;   // present latch contents on rdData
    logic fillNow;     // SRAM read data returns this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/autoinc_ctrl.sv
module autoinc_ctrl
  import autoinc_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrLoad,
  input  logic         rdCmd,
  input  logic         wrCmd,
  input  logic         dummyRd,
  input  logic         dummyWr,
  output ctrlStrobes_t strb
);

  hostOp_e op;
  logic    fillPending;

  // Fixed priority: load, read, write, dummy read, dummy write
  always_comb begin
    if (addrLoad)     op = OP_LOAD;
    else if (rdCmd)   op = OP_READ;
    else if (wrCmd)   op = OP_WRITE;
    else if (dummyRd) op = OP_DUMMY_RD;
    else if (dummyWr) op = OP_DUMMY_WR;
    else              op = OP_NONE;
  end

  always_comb begin
    strb            = '0;
    strb.loadAddr   = (op == OP_LOAD);
    strb.advance    = (op == OP_READ) || (op == OP_WRITE);
    strb.dirWrite   = (op == OP_WRITE);
    strb.memRead    = (op == OP_READ) || (op == OP_DUMMY_RD) || (op == OP_DUMMY_WR);
    strb.readAtNext = (op == OP_READ);
    strb.memWrite   = (op == OP_WRITE);
    strb.outUpdate  = (op == OP_READ) || (op == OP_DUMMY_RD);
    strb.fillNow    = fillPending;
  end

  // One cycle of SRAM latency between a prefetch and its data
  always_ff @(posedge clk) begin
    if (!rstN) fillPending <= 1'b0;
    else       fillPending <= strb.memRead;
  end

endmodule

// File: rtl/autoinc_datapath.sv
module autoinc_datapath
  import autoinc_port_pkg::*;
#(
  parameter int MEM_BYTES = 16384,
  parameter int TX_BYTES  = 3072,
  parameter int LANE_W    = 8,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int WORD_W   = 2 * LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic                wideMode,
  input  logic                wrapEn,
  input  logic [ADDR_W-1:0]   loadValue,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [WORD_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [WORD_W-1:0]   rdData,
  output logic                memEn,
  output logic                memWe,
  output logic [1:0]          memBe,
  output logic [ADDR_W-2:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata
);

  localparam logic [ADDR_W:0]   TX_LIMIT = TX_BYTES[ADDR_W:0];
  localparam logic [ADDR_W-1:0] RX_BASE  = TX_BYTES[ADDR_W-1:0];

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W:0]   sumAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] fetchAddr;
  logic              wrWrap;
  logic              rdWrap;

  logic              fillHigh;
  logic              fillWide;
  logic [WORD_W-1:0] memSel;
  logic [WORD_W-1:0] latchQ;
  logic [WORD_W-1:0] outSrc;
  logic [WORD_W-1:0] rdDataQ;

  // Address arithmetic
  always_comb begin
    effAddr = wideMode ? {addrQ[ADDR_W-1:1], 1'b0} : addrQ;
    sumAddr = {1'b0, effAddr} + (wideMode ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1));
    wrWrap  = wrapEn && strb.dirWrite && ({1'b0, effAddr} < TX_LIMIT) && (sumAddr >= TX_LIMIT);
    rdWrap  = wrapEn && !strb.dirWrite && sumAddr[ADDR_W];
    if (wrWrap)      nextAddr = '0;
    else if (rdWrap) nextAddr = RX_BASE;
    else             nextAddr = sumAddr[ADDR_W-1:0];
    fetchAddr = strb.readAtNext ? nextAddr : effAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              addrQ <= '0;
    else if (strb.loadAddr) addrQ <= loadValue;
    else if (strb.advance)  addrQ <= nextAddr;
  end

  // Lane selection for the fetch in flight
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillHigh <= 1'b0;
      fillWide <= 1'b0;
    end else if (strb.memRead) begin
      fillHigh <= fetchAddr[0] && !wideMode;
      fillWide <= wideMode;
    end
  end

  always_comb begin
    if (fillWide)      memSel = memRdata;
    else if (fillHigh) memSel = {{LANE_W{1'b0}}, memRdata[WORD_W-1:LANE_W]};
    else               memSel = {{LANE_W{1'b0}}, memRdata[LANE_W-1:0]};
    // Bypass lets a read in the fill cycle see the fresh word
    outSrc = strb.fillNow ? memSel : latchQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             latchQ <= '0;
    else if (strb.fillNow) latchQ <= memSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdDataQ <= '0;
    else if (strb.outUpdate) rdDataQ <= outSrc;
  end

  // SRAM port
  always_comb begin
    memEn   = strb.memRead || strb.memWrite;
    memWe   = strb.memWrite;
    memAddr = strb.memRead ? fetchAddr[ADDR_W-1:1] : effAddr[ADDR_W-1:1];
    if (strb.memWrite && !wideMode) memBe = effAddr[0] ? 2'b10 : 2'b01;
    else                            memBe = 2'b11;
  end

  for (genvar g = 0; g < 2; g++) begin : gLane
    assign memWdata[g*LANE_W +: LANE_W] = wideMode ? wrData[g*LANE_W +: LANE_W]
                                                   : wrData[LANE_W-1:0];
  end

  assign curAddr = addrQ;
  assign rdData  = rdDataQ;

endmodule

// File: rtl/autoinc_mem_port.sv
module autoinc_mem_port
  import autoinc_port_pkg::*;
#(
  parameter int MEM_BYTES = 16384,
  parameter int TX_BYTES  = 3072,
  parameter int LANE_W    = 8,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int WORD_W   = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideMode,
  input  logic              wrapEn,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic              dummyRd,
  input  logic              dummyWr,
  input  logic              rdCmd,
  input  logic              wrCmd,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [1:0]        memBe,
  output logic [ADDR_W-2:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);

  ctrlStrobes_t strb;

  autoinc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .addrLoad (addrLoad),
    .rdCmd    (rdCmd),
    .wrCmd    (wrCmd),
    .dummyRd  (dummyRd),
    .dummyWr  (dummyWr),
    .strb     (strb)
  );

  autoinc_datapath #(
    .MEM_BYTES (MEM_BYTES),
    .TX_BYTES  (TX_BYTES),
    .LANE_W    (LANE_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wideMode  (wideMode),
    .wrapEn    (wrapEn),
    .loadValue (loadValue),
    .wrData    (wrData),
    .memRdata  (memRdata),
    .curAddr   (curAddr),
    .rdData    (rdData),
    .memEn     (memEn),
    .memWe     (memWe),
    .memBe     (memBe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

endmodule

// File: rtl/autoinc_mem_port_chk.sv
module autoinc_mem_port_chk #(
  parameter int MEM_BYTES = 16384,
  parameter int TX_BYTES  = 3072,
  localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wideMode,
  input logic              wrapEn,
  input logic              addrLoad,
  input logic [ADDR_W-1:0] loadValue,
  input logic              dummyRd,
  input logic              dummyWr,
  input logic              rdCmd,
  input logic              wrCmd,
  input logic [ADDR_W-1:0] curAddr,
  input logic              memWe,
  input logic [1:0]        memBe
);

  localparam logic [ADDR_W-1:0] TX_TOP = TX_BYTES[ADDR_W-1:0];

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> curAddr == $past(loadValue)); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(addrLoad || rdCmd || wrCmd) |=> $stable(curAddr)); // R10

  AST_WR_WRAP_TX: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEn && wrCmd && !rdCmd && !addrLoad && curAddr < TX_TOP) |=> curAddr < TX_TOP); // R7

  AST_RD_WRAP_RX: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEn && rdCmd && !addrLoad && curAddr >= TX_TOP) |=> curAddr >= TX_TOP); // R8

  AST_NO_DUMMY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((dummyRd || dummyWr) && !(addrLoad || rdCmd || wrCmd)) |-> !memWe); // R10

  AST_WIDE_BOTH_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode && memWe) |-> memBe == 2'b11); // R6

  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!wrapEn && !wideMode && rdCmd && !addrLoad) |=>
      curAddr == ADDR_W'($past(curAddr) + 1'b1)); // R9

endmodule

bind autoinc_mem_port autoinc_mem_port_chk #(
  .MEM_BYTES (MEM_BYTES),
  .TX_BYTES  (TX_BYTES)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wideMode  (wideMode),
  .wrapEn    (wrapEn),
  .addrLoad  (addrLoad),
  .loadValue (loadValue),
  .dummyRd   (dummyRd),
  .dummyWr   (dummyWr),
  .rdCmd     (rdCmd),
  .wrCmd     (wrCmd),
  .curAddr   (curAddr),
  .memWe     (memWe),
  .memBe     (memBe)
);

// File: tb/autoinc_mem_port_tb_top.sv
`timescale 1ns/1ps
module autoinc_mem_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wideMode, wrapEn, addrLoad, dummyRd, dummyWr, rdCmd, wrCmd;
  logic [13:0] loadValue;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic [13:0] curAddr;
  logic        memEn, memWe;
  logic [1:0]  memBe;
  logic [12:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata;

  int nChecks = 0;
  int nErr    = 0;

  always #10 clk = ~clk;

  autoinc_mem_port dut_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .wrapEn(wrapEn),
    .addrLoad(addrLoad), .loadValue(loadValue), .dummyRd(dummyRd),
    .dummyWr(dummyWr), .rdCmd(rdCmd), .wrCmd(wrCmd), .wrData(wrData),
    .rdData(rdData), .curAddr(curAddr), .memEn(memEn), .memWe(memWe),
    .memBe(memBe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // Behavioural single-port SRAM, sparse storage
  logic [15:0] sram [int];
  initial memRdata = '0;
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        logic [15:0] w;
        w = sram.exists(int'(memAddr)) ? sram[int'(memAddr)] : 16'h0;
        if (memBe[0]) w[7:0]  = memWdata[7:0];
        if (memBe[1]) w[15:8] = memWdata[15:8];
        sram[int'(memAddr)] = w;
      end else begin
        memRdata <= sram.exists(int'(memAddr)) ? sram[int'(memAddr)] : 16'h0;
      end
    end
  end

  // Reference model state
  logic [7:0] refMem [int];
  int         expAddr;
  int         expLatch;
  int         expOut;

  function automatic int rdByte(int a);
    return refMem.exists(a & 16383) ? int'(refMem[a & 16383]) : 0;
  endfunction

  function automatic int fetchVal(int a, bit wide);
    if (wide) return (rdByte((a & ~1) + 1) << 8) | rdByte(a & ~1);
    return rdByte(a);
  endfunction

  function automatic int alignAddr(int a, bit wide);
    return wide ? (a & ~1) : a;
  endfunction

  function automatic int stepAddr(int a, bit wide, bit wrap, bit isWr);
    int eff = alignAddr(a, wide);
    int s   = eff + (wide ? 2 : 1);
    if (wrap && isWr && eff < 3072 && s >= 3072) return 0;
    if (wrap && !isWr && s >= 16384) return 3072;
    return s & 16383;
  endfunction

  task automatic chkEq(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic endOp(string tag);
    @(negedge clk);
    addrLoad = 0; dummyRd = 0; dummyWr = 0; rdCmd = 0; wrCmd = 0;
    chkEq(tag, "curAddr", int'(curAddr), expAddr);
    chkEq(tag, "rdData", int'(rdData), expOut);
  endtask

  task automatic opLoad(int a, bit withRd, string tag);
    addrLoad = 1; loadValue = a[13:0]; rdCmd = withRd;
    expAddr = a;
    endOp(tag);
  endtask

  task automatic opRead(bit withWr, int d, string tag);
    rdCmd = 1; wrCmd = withWr; wrData = d[15:0];
    expOut  = expLatch;
    expAddr = stepAddr(expAddr, wideMode, wrapEn, 1'b0);
    expLatch = fetchVal(expAddr, wideMode);
    endOp(tag);
  endtask

  task automatic opWrite(int d, string tag);
    int eff = alignAddr(expAddr, wideMode);
    wrCmd = 1; wrData = d[15:0];
    refMem[eff] = d[7:0];
    if (wideMode) refMem[eff + 1] = d[15:8];
    expAddr = stepAddr(expAddr, wideMode, wrapEn, 1'b1);
    endOp(tag);
  endtask

  task automatic opDummyRd(string tag);
    dummyRd = 1;
    expOut   = expLatch;
    expLatch = fetchVal(alignAddr(expAddr, wideMode), wideMode);
    endOp(tag);
  endtask

  task automatic opDummyWr(bit withDrd, string tag);
    dummyWr = 1; dummyRd = withDrd;
    if (withDrd) expOut = expLatch;
    expLatch = fetchVal(alignAddr(expAddr, wideMode), wideMode);
    endOp(tag);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7421));
    rstN = 0; wideMode = 0; wrapEn = 0; addrLoad = 0; dummyRd = 0;
    dummyWr = 0; rdCmd = 0; wrCmd = 0; loadValue = '0; wrData = '0;
    expAddr = 0; expLatch = 0; expOut = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chkEq("R1", "curAddr", int'(curAddr), 0);
    chkEq("R1", "rdData", int'(rdData), 0);
    chkEq("R1", "memEn", int'(memEn), 0);
    rstN = 1;
    @(negedge clk);
    chkEq("R1", "memEn idle", int'(memEn), 0);

    // R2 load, R6 narrow writes
    opLoad(16'h0100, 0, "R2");
    opWrite(16'h0011, "R6");
    opWrite(16'h0022, "R6");
    opWrite(16'h0033, "R6");
    // R3 dummy read returns stale latch (0 after reset)
    opLoad(16'h0100, 0, "R2");
    opDummyRd("R3");
    // R4 back-to-back reads, R5 narrow upper byte zero
    opRead(0, 0, "R4");
    opRead(0, 0, "R4");
    opRead(0, 0, "R5");

    // R5 wide little-endian
    wideMode = 1;
    opLoad(16'h0201, 0, "R2");
    opWrite(16'hBEEF, "R5");
    opWrite(16'hCAFE, "R5");
    opLoad(16'h0200, 0, "R2");
    opDummyRd("R3");
    opRead(0, 0, "R5");
    opRead(0, 0, "R5");
    wideMode = 0;
    opLoad(16'h0203, 0, "R2");
    opDummyRd("R3");
    opRead(0, 0, "R5");

    // R7 write wrap
    wrapEn = 1;
    opLoad(16'h0BFE, 0, "R2");
    opWrite(16'h00A1, "R7");
    opWrite(16'h00A2, "R7");
    opWrite(16'h00A3, "R7");
    wideMode = 1;
    opLoad(16'h0BFE, 0, "R2");
    opWrite(16'h1234, "R7");
    // R8 read wrap
    wideMode = 0;
    opLoad(16'h3FFE, 0, "R2");
    opDummyRd("R3");
    opRead(0, 0, "R8");
    opRead(0, 0, "R8");
    wideMode = 1;
    opLoad(16'h3FFE, 0, "R2");
    opRead(0, 0, "R8");
    // R9 no wrap
    wrapEn = 0; wideMode = 0;
    opLoad(16'h3FFF, 0, "R2");
    opRead(0, 0, "R9");
    opLoad(16'h0BFF, 0, "R2");
    opWrite(16'h0055, "R9");

    // R10 dummy write: no write, no move
    opLoad(16'h0100, 0, "R2");
    wrData = 16'h00EE;
    opDummyWr(0, "R10");
    opRead(0, 0, "R10");

    // R11 priority
    opLoad(16'h0300, 1, "R11");
    opRead(1, 16'h0077, "R11");
    opDummyWr(1, "R11");
    opLoad(16'h0300, 0, "R2");
    opDummyRd("R11");
    opRead(0, 0, "R11");

    // R4/R5/R6/R12 random traffic
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 16);
      if (r == 0)       opLoad(int'($urandom % 16384), 0, "R12");
      else if (r == 1)  wideMode = ~wideMode;
      else if (r == 2)  wrapEn = ~wrapEn;
      else if (r == 3)  opDummyRd("R3");
      else if (r == 4)  opDummyWr(0, "R10");
      else if (r < 10)  opRead(0, 0, "R4");
      else              opWrite(int'($urandom % 65536), "R6");
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule